// File: doc/BRIEF.md
# Caller-ID Mode Discriminator and Gate

This block sits behind a tone demodulator on an analog telephone line interface. It receives one recovered bit per bit period, together with a one-cycle sample strobe, and decides whether the caller-ID burst on the line is frequency-shift keyed data or DTMF signalling. A frequency-shift keyed burst opens with a channel-seizure preamble of alternating ones and zeros, followed by a run of steady mark (one) bits. A burst without that header is taken as DTMF, and the mode output stays low.

When the preamble and then enough mark bits have been seen, the block raises the mode output. One bit period later it drives the active-low valid output low. From then on it forwards the sampled bits to the serial output, which carries the asynchronous characters: a zero start bit, eight data bits least significant first, and a one stop bit. The preamble and the mark run never reach the serial output, which idles high until forwarding starts. A long run of idle marks ends the session. A power-down input forces the serial and valid outputs high at once and returns the block to idle.

All decisions are taken on the clock edge where the sample strobe is high. Each output changes on that edge.

Top module: `cid_mode_gate`

## Requirements
- R1: After reset, `fsk_mode` is 0, `data_valid_n` is 1 and `data_out` is 1.
- R2: Seizure is declared only after SEIZE_MIN consecutive sampled bits in which each bit differs from the one before it. A shorter alternating run followed by marks leaves `fsk_mode` at 0 and `data_valid_n` at 1.
- R3: Once seizure is declared, `fsk_mode` rises on the strobe that samples the MARK_FLAG-th consecutive one (MARK_FLAG is at least 2).
- R4: `data_valid_n` falls on the strobe of the next consecutive one, exactly one bit period after `fsk_mode` rose. With the default MARK_FLAG of 3 this keeps the fall within 3.75 ms of the start of the mark run at 1200 baud.
- R5: `data_out` stays 1 throughout the preamble and the mark run. After `data_valid_n` has fallen, each strobe drives `data_out` to the bit it samples.
- R6: Two consecutive sampled zeros after seizure is declared, but before `data_valid_n` falls, abandon the burst. The block returns to idle with `fsk_mode` at 0.
- R7: While forwarding, TIMEOUT_BITS consecutive sampled ones return the block to idle on the strobe of the last of them: `fsk_mode` goes to 0 and `data_valid_n` goes to 1. The default of 240 bits is 200 ms at 1200 baud.
- R8: While `pdwn` is 1, `data_out` and `data_valid_n` read 1 in the same cycle, without waiting for a clock edge. Strobes are ignored, and after the next clock edge `fsk_mode` is 0 and the block is idle.
- R9: When `bit_stb` is 0, `bit_in` has no effect: all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pdwn | input | 1 | Power-down, active high |
| bit_in | input | 1 | Demodulated line bit |
| bit_stb | input | 1 | One-cycle strobe at the middle of each bit period |
| fsk_mode | output | 1 | 1 while a frequency-shift keyed burst is recognised, 0 otherwise |
| data_valid_n | output | 1 | Active-low valid output, low while characters are forwarded |
| data_out | output | 1 | Gated serial data, idles high |

## Verification
The bench builds the block with SEIZE_MIN of 6 and TIMEOUT_BITS of 24, and keeps MARK_FLAG at 3. The short preamble lets several bursts fit in a short run: a valid one, one that alternates too briefly, one abandoned by a double zero, and one interrupted by power-down. The small timeout makes the idle-mark exit reachable after a full character and also when no start bit arrives. Because MARK_FLAG keeps its default, the mode-then-valid spacing is checked at the value used in service.

// File: rtl/cid_mode_gate.sv
module cid_mode_gate #(
  parameter int SEIZE_MIN    = 16,
  parameter int MARK_FLAG    = 3,
  parameter int TIMEOUT_BITS = 240
) (
  input  logic clk,
  input  logic rst,
  input  logic pdwn,
  input  logic bit_in,
  input  logic bit_stb,
  output logic fsk_mode,
  output logic data_valid_n,
  output logic data_out
);

  localparam int AW = $clog2(SEIZE_MIN + 1);
  localparam int RW = $clog2(MARK_FLAG + 2);
  localparam int TW = $clog2(TIMEOUT_BITS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SEIZE, ST_DATA} st_t;

  st_t         state_q;
  logic        prev_q, mode_q, dv_q, dout_q;
  logic [AW-1:0] alt_q, alt_nxt;
  logic [RW-1:0] run_q, run_nxt;
  logic [TW-1:0] tmo_q, tmo_nxt;

  always_comb begin
    if (alt_q == '0 || bit_in != prev_q)
      alt_nxt = (alt_q == AW'(SEIZE_MIN)) ? alt_q : alt_q + AW'(1);
    else
      alt_nxt = AW'(1);
    if (bit_in)
      run_nxt = (run_q == RW'(MARK_FLAG + 1)) ? run_q : run_q + RW'(1);
    else
      run_nxt = '0;
    tmo_nxt = bit_in ? tmo_q + TW'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || pdwn) begin
      state_q <= ST_IDLE;
      prev_q  <= 1'b0;
      alt_q   <= '0;
      run_q   <= '0;
      tmo_q   <= '0;
      mode_q  <= 1'b0;
      dv_q    <= 1'b1;
      dout_q  <= 1'b1;
    end else if (bit_stb) begin
      prev_q <= bit_in;
      case (state_q)
        ST_IDLE: begin
          alt_q <= alt_nxt;
          if (alt_nxt == AW'(SEIZE_MIN)) begin
            state_q <= ST_SEIZE;
            run_q   <= RW'(bit_in);
          end
        end
        ST_SEIZE: begin
          if (!bit_in && !prev_q) begin
            state_q <= ST_IDLE;
            alt_q   <= AW'(1);
            run_q   <= '0;
            mode_q  <= 1'b0;
          end else begin
            run_q  <= run_nxt;
            mode_q <= (run_nxt >= RW'(MARK_FLAG));
            if (run_nxt == RW'(MARK_FLAG + 1)) begin
              state_q <= ST_DATA;
              dv_q    <= 1'b0;
              tmo_q   <= '0;
            end
          end
        end
        ST_DATA: begin
          if (bit_in && tmo_nxt == TW'(TIMEOUT_BITS)) begin
            state_q <= ST_IDLE;
            alt_q   <= AW'(1);
            run_q   <= '0;
            tmo_q   <= '0;
            mode_q  <= 1'b0;
            dv_q    <= 1'b1;
            dout_q  <= 1'b1;
          end else begin
            tmo_q  <= tmo_nxt;
            dout_q <= bit_in;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fsk_mode     = mode_q;
  assign data_valid_n = dv_q | pdwn;
  assign data_out     = dout_q | pdwn;

  assert_valid_has_mode_R3: assert property (@(posedge clk) disable iff (rst)
    !dv_q |-> mode_q);

  assert_mode_leads_valid_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(dv_q) |-> $past(mode_q));

  assert_preamble_hidden_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_DATA) |-> dout_q);

  assert_timeout_bound_R7: assert property (@(posedge clk) disable iff (rst)
    tmo_q < TW'(TIMEOUT_BITS));

  assert_pdwn_idles_R8: assert property (@(posedge clk) disable iff (rst)
    pdwn |=> (state_q == ST_IDLE && !mode_q && dv_q));

  assert_hold_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (!bit_stb && !pdwn) |=> ($stable(dout_q) && $stable(mode_q) && $stable(dv_q)));

endmodule

// File: tb/cid_mode_gate_tb_top.sv
`timescale 1ns/1ps
module cid_mode_gate_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pdwn = 1'b0;
  logic din = 1'b0;
  logic stb = 1'b0;
  logic mode, dvn, dout;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic due = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  localparam logic [2:0] IDLE3 = 3'b011;

  always #4 clk = ~clk;

  cid_mode_gate #(.SEIZE_MIN(6), .MARK_FLAG(3), .TIMEOUT_BITS(24)) dut_i (
    .clk(clk), .rst(rst), .pdwn(pdwn), .bit_in(din), .bit_stb(stb),
    .fsk_mode(mode), .data_valid_n(dvn), .data_out(dout));

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {mode,valid_n,dout} actual %b expected %b", tag, act, exp);
    end
  endtask

  always @(posedge clk) due <= stb;

  always @(negedge clk) begin
    if (due) begin
      if (exp_q.size() == 0) chk("queue", 3'bxxx, 3'b000);
      else chk(tag_q.pop_front(), {mode, dvn, dout}, exp_q.pop_front());
    end
  end

  task automatic send(input logic b, input logic [2:0] e, input string tag);
    @(negedge clk);
    din = b;
    stb = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic enter_data();
    for (int i = 0; i < 6; i++) send(~i[0], IDLE3, "R2");
    send(1'b1, IDLE3, "R5");
    send(1'b1, IDLE3, "R5");
    send(1'b1, 3'b111, "R3");
    send(1'b1, 3'b101, "R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {mode, dvn, dout}, IDLE3);

    // R2: alternating run too short, then marks
    for (int i = 0; i < 4; i++) send(~i[0], IDLE3, "R2");
    for (int i = 0; i < 8; i++) send(1'b1, IDLE3, "R2");

    // full burst, one character 0x35, then idle marks time out (R5, R7)
    enter_data();
    send(1'b0, 3'b100, "R5");
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ch = 8'h35;
      send(ch[i], {2'b10, ch[i]}, "R5");
    end
    send(1'b1, 3'b101, "R5");
    for (int i = 0; i < 22; i++) send(1'b1, 3'b101, "R7");
    send(1'b1, IDLE3, "R7");

    // no start bit at all: timeout straight after valid falls
    enter_data();
    for (int i = 0; i < 23; i++) send(1'b1, 3'b101, "R7");
    send(1'b1, IDLE3, "R7");

    // R6: double zero after seizure abandons the burst
    for (int i = 0; i < 6; i++) send(~i[0], IDLE3, "R6");
    send(1'b0, IDLE3, "R6");
    for (int i = 0; i < 4; i++) send(1'b1, IDLE3, "R6");

    // R9 then R8
    enter_data();
    send(1'b0, 3'b100, "R5");
    @(negedge clk);
    din = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9", {mode, dvn, dout}, 3'b100);
    pdwn = 1'b1;
    #1;
    chk("R8", {dvn, dout}, 3'b011);
    @(negedge clk);
    chk("R8", {mode, dvn, dout}, IDLE3);
    send(1'b0, IDLE3, "R8");
    send(1'b1, IDLE3, "R8");
    pdwn = 1'b0;
    for (int i = 0; i < 4; i++) send(1'b1, IDLE3, "R8");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) chk("queue", 3'(exp_q.size()), 3'b000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule